// File: doc/BRIEF.md
# Home Directory Line-State Tracker

This block is the home-side coherence directory for a small, fixed set of memory lines shared by several caches. For each line it records a stable state of I, S, O or M, the ID of the owning cache, and a vector with one bit per sharing cache. Each cycle it accepts one message from a cache: a shared read request, an exclusive request, a writeback, or an unblock. It answers with a registered response one cycle later.

A response either grants data from memory, forwards the request to the current owner, grants a permission upgrade, acknowledges a writeback, or asks the sender to retry. Exclusive requests also carry an invalidation mask for the other sharers. The response tells the requester how many invalidation acknowledgments to expect, because the directory does not collect those acknowledgments itself.

After a read or exclusive request, the line stays locked until the requester sends an unblock. Memory reads and writes appear as one-cycle strobes together with the line index. The network is represented by the request inputs and the response outputs.

Top module: `dir_tracker`

## Requirements
- R1: After reset every line is in I with no owner, no sharers and not busy, and `rspValid`, `memRdEn` and `memWrEn` are low. Until the first request, no response is produced.
- R2: A read request (`reqType`=0) to a line in I or S gets a response one cycle later. The response has kind MEMDATA (`rspKind`=1), `memRdEn` high for that line, an empty invalidation mask and a zero count. The requester joins the sharers and the line becomes S.
- R3: A read request to a line in M or O gets kind FWD (`rspKind`=2) with `rspOwner` set to the owner, and no memory read. The requester joins the sharers and the line becomes O.
- R4: An exclusive request (`reqType`=1) returns in `invMask` every sharer except the requester, and in `ackCount` the number of bits set in that mask. The kind is FWD if another cache owns the line (O or M). It is GRANT (`rspKind`=3) if the requester already owns it. It is MEMDATA with `memRdEn` if the line is in I or S. Afterwards the line is in M, the requester is the owner and the sharer vector is empty.
- R5: After a read or exclusive request, the line is busy. Any read, exclusive or writeback message to it gets RETRY (`rspKind`=0) and changes no state, until the recorded requester sends an unblock.
- R6: An unblock (`reqType`=3) never produces a response. An unblock from a node other than the recorded requester, or to a line that is not busy, changes nothing.
- R7: A writeback (`reqType`=2) from the owner of a line in M or O produces WBACK (`rspKind`=4) with `memWrEn` high. Afterwards the line is in I if no sharers remain, or in S if sharers remain. The line does not become busy.
- R8: A writeback from a node that does not own the line produces WBACK with `memWrEn` low, and leaves the line unchanged.
- R9: Lines are independent. A busy line does not affect requests to other lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A message is present this cycle |
| reqType | input | 2 | 0 read, 1 exclusive, 2 writeback, 3 unblock |
| reqNode | input | $clog2(NUM_NODES) | Sending cache ID |
| reqLine | input | $clog2(NUM_LINES) | Target line index |
| rspValid | output | 1 | Response present |
| rspKind | output | 3 | 0 RETRY, 1 MEMDATA, 2 FWD, 3 GRANT, 4 WBACK |
| rspDest | output | $clog2(NUM_NODES) | Cache that sent the request |
| rspOwner | output | $clog2(NUM_NODES) | Owner that the request is forwarded to |
| invMask | output | NUM_NODES | Caches that must invalidate |
| ackCount | output | $clog2(NUM_NODES+1) | Acknowledgments the requester must collect |
| memRdEn | output | 1 | Memory read of `rspLine` |
| memWrEn | output | 1 | Memory write of `rspLine` |
| rspLine | output | $clog2(NUM_LINES) | Line the response refers to |

## Verification
The bench walks one line through every stable state and sends each request type in each state, so that it can tell apart memory-sourced, forwarded and upgrade grants. Exclusive requests are issued with no sharers, one sharer, three sharers, and with the requester itself already a sharer or the owner. This separates the masking of the requester from the plain sharer count. After a writeback, a following exclusive request shows through its mask and kind whether the line fell to I or to S. Busy-line patterns send interleaved retries, foreign unblocks and requests to a second line, which separates the per-line lock from a global one.

// File: rtl/dir_pkg.sv
package dir_pkg;

  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_O = 2'd2, ST_M = 2'd3} lineState_e;

  typedef enum logic [1:0] {
    MSG_GETS = 2'd0, MSG_GETX = 2'd1, MSG_PUT = 2'd2, MSG_UNBLOCK = 2'd3
  } msg_e;

  typedef enum logic [2:0] {
    RSP_RETRY = 3'd0, RSP_MEMDATA = 3'd1, RSP_FWD = 3'd2, RSP_GRANT = 3'd3, RSP_WBACK = 3'd4
  } rsp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       respond;
    rsp_e       kind;
    logic       wrState;
    lineState_e nextState;
    logic       addSharer;
    logic       clearSharers;
    logic       setOwner;
    logic       setBusy;
    logic       clearBusy;
    logic       sendInv;
    logic       memRd;
    logic       memWr;
  } ctrlStrobe_t;

endpackage

// File: rtl/dir_ctrl.sv
module dir_ctrl
  import dir_pkg::*;
(
  input  logic        reqValid,
  input  logic [1:0]  reqType,
  input  lineState_e  curState,
  input  logic        curBusy,
  input  logic        isOwner,
  input  logic        isPending,
  input  logic        hasSharers,
  output ctrlStrobe_t strobe
);

  logic ownedLine;
  assign ownedLine = (curState == ST_M) || (curState == ST_O);

  always_comb begin
    strobe = '0;
    if (reqValid) begin
      if (msg_e'(reqType) == MSG_UNBLOCK) begin
        strobe.clearBusy = curBusy && isPending;
      end else if (curBusy) begin
        strobe.respond = 1'b1;
        strobe.kind    = RSP_RETRY;
      end else begin
        strobe.respond = 1'b1;
        case (msg_e'(reqType))
          MSG_GETS: begin
            strobe.addSharer = 1'b1;
            strobe.setBusy   = 1'b1;
            strobe.wrState   = 1'b1;
            if (ownedLine) begin
              strobe.kind      = RSP_FWD;
              strobe.nextState = ST_O;
            end else begin
              strobe.kind      = RSP_MEMDATA;
              strobe.memRd     = 1'b1;
              strobe.nextState = ST_S;
            end
          end
          MSG_GETX: begin
            strobe.sendInv      = 1'b1;
            strobe.clearSharers = 1'b1;
            strobe.setOwner     = 1'b1;
            strobe.setBusy      = 1'b1;
            strobe.wrState      = 1'b1;
            strobe.nextState    = ST_M;
            if (ownedLine) begin
              strobe.kind = isOwner ? RSP_GRANT : RSP_FWD;
            end else begin
              strobe.kind  = RSP_MEMDATA;
              strobe.memRd = 1'b1;
            end
          end
          default: begin
            strobe.kind = RSP_WBACK;
            if (ownedLine && isOwner) begin
              strobe.memWr     = 1'b1;
              strobe.wrState   = 1'b1;
              strobe.nextState = hasSharers ? ST_S : ST_I;
            end
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/dir_datapath.sv
module dir_datapath
  import dir_pkg::*;
#(
  parameter int NUM_NODES = 4,
  parameter int NUM_LINES = 4,
  localparam int NW = $clog2(NUM_NODES),
  localparam int LW = $clog2(NUM_LINES),
  localparam int CW = $clog2(NUM_NODES + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NW-1:0]        reqNode,
  input  logic [LW-1:0]        reqLine,
  input  ctrlStrobe_t          strobe,
  output lineState_e           curState,
  output logic                 curBusy,
  output logic                 isOwner,
  output logic                 isPending,
  output logic                 hasSharers,
  output logic                 rspValid,
  output logic [2:0]           rspKind,
  output logic [NW-1:0]        rspDest,
  output logic [NW-1:0]        rspOwner,
  output logic [NUM_NODES-1:0] invMask,
  output logic [CW-1:0]        ackCount,
  output logic                 memRdEn,
  output logic                 memWrEn,
  output logic [LW-1:0]        rspLine
);

  lineState_e           stateQ   [NUM_LINES];
  logic [NW-1:0]        ownerQ   [NUM_LINES];
  logic [NW-1:0]        pendQ    [NUM_LINES];
  logic [NUM_NODES-1:0] sharersQ [NUM_LINES];
  logic [NUM_LINES-1:0] busyQ;

  logic [NUM_NODES-1:0] reqBit;
  logic [NUM_NODES-1:0] invNext;
  logic [CW-1:0]        ackNext;

  always_comb begin
    for (int i = 0; i < NUM_NODES; i++) reqBit[i] = (reqNode == NW'(i));
  end

  assign curState   = stateQ[reqLine];
  assign curBusy    = busyQ[reqLine];
  assign isOwner    = (ownerQ[reqLine] == reqNode);
  assign isPending  = (pendQ[reqLine] == reqNode);
  assign hasSharers = |sharersQ[reqLine];
  assign invNext    = strobe.sendInv ? (sharersQ[reqLine] & ~reqBit) : '0;

  always_comb begin
    ackNext = '0;
    for (int i = 0; i < NUM_NODES; i++) ackNext = ackNext + CW'(invNext[i]);
  end

  generate
    for (genvar g = 0; g < NUM_LINES; g++) begin : gLine
      logic hit;
      assign hit = (reqLine == LW'(g));

      always_ff @(posedge clk) begin
        if (!rstN) begin
          stateQ[g]   <= ST_I;
          ownerQ[g]   <= '0;
          pendQ[g]    <= '0;
          sharersQ[g] <= '0;
          busyQ[g]    <= 1'b0;
        end else if (hit) begin
          if (strobe.wrState) stateQ[g] <= strobe.nextState;
          if (strobe.setOwner) ownerQ[g] <= reqNode;
          if (strobe.clearSharers) sharersQ[g] <= '0;
          else if (strobe.addSharer) sharersQ[g] <= sharersQ[g] | reqBit;
          if (strobe.setBusy) begin
            busyQ[g] <= 1'b1;
            pendQ[g] <= reqNode;
          end else if (strobe.clearBusy) begin
            busyQ[g] <= 1'b0;
          end
        end
      end

      AST_M_NO_SHARERS: assert property (@(posedge clk) disable iff (!rstN)
        stateQ[g] == ST_M |-> sharersQ[g] == '0); // R4
      AST_I_NO_SHARERS: assert property (@(posedge clk) disable iff (!rstN)
        stateQ[g] == ST_I |-> sharersQ[g] == '0); // R7
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspKind  <= '0;
      rspDest  <= '0;
      rspOwner <= '0;
      invMask  <= '0;
      ackCount <= '0;
      memRdEn  <= 1'b0;
      memWrEn  <= 1'b0;
      rspLine  <= '0;
    end else begin
      rspValid <= strobe.respond;
      rspKind  <= strobe.kind;
      rspDest  <= reqNode;
      rspOwner <= ownerQ[reqLine];
      invMask  <= invNext;
      ackCount <= ackNext;
      memRdEn  <= strobe.memRd;
      memWrEn  <= strobe.memWr;
      rspLine  <= reqLine;
    end
  end

  AST_INV_SKIPS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !invMask[rspDest]); // R4
  AST_MEM_ONE_DIR: assert property (@(posedge clk) disable iff (!rstN)
    !(memRdEn && memWrEn)); // R2
  AST_FWD_TO_OTHER: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspKind == RSP_FWD |-> rspOwner != rspDest); // R3

endmodule

// File: rtl/dir_tracker.sv
module dir_tracker
  import dir_pkg::*;
#(
  parameter int NUM_NODES = 4,
  parameter int NUM_LINES = 4,
  localparam int NW = $clog2(NUM_NODES),
  localparam int LW = $clog2(NUM_LINES),
  localparam int CW = $clog2(NUM_NODES + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [1:0]           reqType,
  input  logic [NW-1:0]        reqNode,
  input  logic [LW-1:0]        reqLine,
  output logic                 rspValid,
  output logic [2:0]           rspKind,
  output logic [NW-1:0]        rspDest,
  output logic [NW-1:0]        rspOwner,
  output logic [NUM_NODES-1:0] invMask,
  output logic [CW-1:0]        ackCount,
  output logic                 memRdEn,
  output logic                 memWrEn,
  output logic [LW-1:0]        rspLine
);

  ctrlStrobe_t strobe;
  lineState_e  curState;
  logic        curBusy, isOwner, isPending, hasSharers;

  dir_ctrl uCtrl (
    .reqValid  (reqValid),
    .reqType   (reqType),
    .curState  (curState),
    .curBusy   (curBusy),
    .isOwner   (isOwner),
    .isPending (isPending),
    .hasSharers(hasSharers),
    .strobe    (strobe)
  );

  dir_datapath #(.NUM_NODES(NUM_NODES), .NUM_LINES(NUM_LINES)) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .reqNode   (reqNode),
    .reqLine   (reqLine),
    .strobe    (strobe),
    .curState  (curState),
    .curBusy   (curBusy),
    .isOwner   (isOwner),
    .isPending (isPending),
    .hasSharers(hasSharers),
    .rspValid  (rspValid),
    .rspKind   (rspKind),
    .rspDest   (rspDest),
    .rspOwner  (rspOwner),
    .invMask   (invMask),
    .ackCount  (ackCount),
    .memRdEn   (memRdEn),
    .memWrEn   (memWrEn),
    .rspLine   (rspLine)
  );

  AST_BUSY_RETRY: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && curBusy && reqType != 2'd3 |=> rspValid && rspKind == 3'd0); // R5
  AST_UNBLOCK_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqType == 2'd3 |=> !rspValid); // R6

endmodule

// File: tb/tb_dir_tracker.sv
module tb_dir_tracker;

  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int L = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic [1:0] reqType = '0;
  logic [1:0] reqNode = '0;
  logic [1:0] reqLine = '0;
  logic       rspValid;
  logic [2:0] rspKind;
  logic [1:0] rspDest, rspOwner;
  logic [3:0] invMask;
  logic [2:0] ackCount;
  logic       memRdEn, memWrEn;
  logic [1:0] rspLine;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  localparam logic [1:0] GETS = 2'd0, GETX = 2'd1, PUT = 2'd2, UNBL = 2'd3;
  localparam logic [2:0] K_RETRY = 3'd0, K_MEM = 3'd1, K_FWD = 3'd2, K_GRANT = 3'd3, K_WB = 3'd4;

  typedef struct {
    logic [2:0] kind;
    logic [1:0] dest;
    logic [1:0] owner;
    logic [3:0] inv;
    logic [2:0] ack;
    logic       rd;
    logic       wr;
    logic [1:0] line;
    string      tag;
  } expItem_t;

  expItem_t expQ[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  dir_tracker #(.NUM_NODES(N), .NUM_LINES(L)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqType(reqType),
    .reqNode(reqNode), .reqLine(reqLine), .rspValid(rspValid), .rspKind(rspKind),
    .rspDest(rspDest), .rspOwner(rspOwner), .invMask(invMask), .ackCount(ackCount),
    .memRdEn(memRdEn), .memWrEn(memWrEn), .rspLine(rspLine)
  );

  // driver: one message per cycle, expected response pushed to scoreboard
  task automatic send(input logic [1:0] t, input int node, input int line,
                      input logic [2:0] kind, input int own, input logic [3:0] inv,
                      input int ack, input bit rd, input bit wr, input string tag);
    expItem_t e;
    @(negedge clk);
    reqValid = 1'b1;
    reqType  = t;
    reqNode  = 2'(node);
    reqLine  = 2'(line);
    if (t != UNBL) begin
      e.kind = kind; e.dest = 2'(node); e.owner = 2'(own); e.inv = inv;
      e.ack = 3'(ack); e.rd = rd; e.wr = wr; e.line = 2'(line); e.tag = tag;
      expQ.push_back(e);
    end
  endtask

  task automatic unblock(input int node, input int line);
    send(UNBL, node, line, K_RETRY, 0, 4'b0, 0, 0, 0, "R6");
  endtask

  task automatic idle();
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  // monitor: compare each produced response with the scoreboard head
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (rspValid) begin
        checks++;
        if (expQ.size() == 0) begin
          failures++;
          $display("FAIL R6: unexpected response kind=%0d dest=%0d (expected none)", rspKind, rspDest);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          if (rspKind !== e.kind || rspDest !== e.dest || invMask !== e.inv ||
              ackCount !== e.ack || memRdEn !== e.rd || memWrEn !== e.wr ||
              rspLine !== e.line || (e.kind == K_FWD && rspOwner !== e.owner)) begin
            failures++;
            $display("FAIL %s: got kind=%0d dest=%0d own=%0d inv=%b ack=%0d rd=%0b wr=%0b line=%0d, expected kind=%0d dest=%0d own=%0d inv=%b ack=%0d rd=%0b wr=%0b line=%0d",
                     e.tag, rspKind, rspDest, rspOwner, invMask, ackCount, memRdEn, memWrEn, rspLine,
                     e.kind, e.dest, e.owner, e.inv, e.ack, e.rd, e.wr, e.line);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (rspValid !== 1'b0 || memRdEn !== 1'b0 || memWrEn !== 1'b0) begin
      failures++;
      $display("FAIL R1: outputs in reset rsp=%0b rd=%0b wr=%0b, expected 0 0 0", rspValid, memRdEn, memWrEn);
    end
    rstN = 1'b1;
    idle();
    idle();

    // R2 read from I, then R5/R6 busy handling
    send(GETS, 1, 0, K_MEM, 0, 4'b0000, 0, 1, 0, "R2");
    send(GETS, 2, 0, K_RETRY, 0, 4'b0000, 0, 0, 0, "R5");
    unblock(3, 0);                                          // R6 foreign unblock
    send(GETS, 2, 0, K_RETRY, 0, 4'b0000, 0, 0, 0, "R6");
    send(PUT, 1, 0, K_RETRY, 0, 4'b0000, 0, 0, 0, "R5");
    unblock(1, 0);
    unblock(1, 0);                                          // R6 unblock of idle line
    send(GETS, 2, 0, K_MEM, 0, 4'b0000, 0, 1, 0, "R2");
    unblock(2, 0);
    // R4 exclusive from S, requester already a sharer
    send(GETX, 1, 0, K_MEM, 0, 4'b0100, 1, 1, 0, "R4");
    unblock(1, 0);
    // R3 read from M
    send(GETS, 3, 0, K_FWD, 1, 4'b0000, 0, 0, 0, "R3");
    unblock(3, 0);
    // R4 exclusive from O by another node
    send(GETX, 0, 0, K_FWD, 1, 4'b1000, 1, 0, 0, "R4");
    unblock(0, 0);
    // R8 stale writeback
    send(PUT, 2, 0, K_WB, 0, 4'b0000, 0, 0, 0, "R8");
    send(GETS, 1, 0, K_FWD, 0, 4'b0000, 0, 0, 0, "R8");
    unblock(1, 0);
    // R4 upgrade by owner in O
    send(GETX, 0, 0, K_GRANT, 0, 4'b0010, 1, 0, 0, "R4");
    unblock(0, 0);
    // R7 writeback from O with sharer left -> S
    send(GETS, 2, 0, K_FWD, 0, 4'b0000, 0, 0, 0, "R3");
    unblock(2, 0);
    send(PUT, 0, 0, K_WB, 0, 4'b0000, 0, 0, 1, "R7");
    send(GETX, 3, 0, K_MEM, 0, 4'b0100, 1, 1, 0, "R7");
    unblock(3, 0);
    // R7 writeback from M -> I
    send(PUT, 3, 0, K_WB, 0, 4'b0000, 0, 0, 1, "R7");
    send(GETX, 1, 0, K_MEM, 0, 4'b0000, 0, 1, 0, "R7");
    unblock(1, 0);
    // R9 per-line lock
    send(GETX, 2, 2, K_MEM, 0, 4'b0000, 0, 1, 0, "R9");
    send(GETS, 0, 1, K_MEM, 0, 4'b0000, 0, 1, 0, "R9");
    send(GETS, 0, 2, K_RETRY, 0, 4'b0000, 0, 0, 0, "R9");
    unblock(2, 2);
    unblock(0, 1);
    send(GETS, 0, 2, K_FWD, 2, 4'b0000, 0, 0, 0, "R9");
    unblock(0, 2);
    // R4 full sharer set on line 3
    for (int n = 0; n < N; n++) begin
      send(GETS, n, 3, K_MEM, 0, 4'b0000, 0, 1, 0, "R2");
      unblock(n, 3);
    end
    send(GETX, 1, 3, K_MEM, 0, 4'b1101, 3, 1, 0, "R4");
    unblock(1, 3);
    idle();
    idle();
    idle();
    done = 1;
    checks++;
    if (expQ.size() != 0) begin
      failures++;
      $display("FAIL R5: %0d responses missing, expected 0", expQ.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule